// File: doc/BRIEF.md
# Two-Thread Partitioned Store Queue

This block holds the pending stores of a core that runs two hardware threads. Each thread owns a fixed half of the entries, and the other thread can never borrow them. The issue stage reserves an entry in program order and receives its slot number. The address operation and the data operation later write that slot independently, in either order. When the retirement logic retires a store, the entry becomes eligible to write the data cache. Entries of each thread leave through a single cache write port in program order. They free their slot only when that write is accepted.

Loads probe the queue in the same cycle for store-to-load forwarding. A probe names its thread and carries the thread's allocation pointer as it stood when the load issued, which marks where the load sits among that thread's stores. The queue searches only that thread's older stores. If the youngest matching one can supply every requested byte, its data is returned. If not, the load is told to wait and replay. A per-thread flush throws away the thread's speculative entries. Its retired entries keep draining.

Top module: `smt_store_buffer`

## Requirements
- R1: Each thread allocates slots 0,1,..,DEPTH-1 of its own half in cyclic order, and `alloc_idx` shows the slot granted to `alloc_tid`. `alloc_ready` is low exactly when that thread already holds DEPTH uncommitted entries, or when a flush of that thread is presented in the same cycle. The other thread's occupancy has no influence.
- R2: The address write and the data write for a slot may come in either order. A slot is eligible for the cache only after both have arrived.
- R3: No entry is offered on the cache write port before its store has retired. A retire with `ret_tid` marks the oldest non-retired entry of that thread.
- R4: For each thread, the cache write port carries entries in allocation order, with the address, byte mask and data of that entry. A slot stays occupied, and counts toward R1, until its write is accepted.
- R5: The cache write port is valid/ready. Once `cw_valid` is high, `cw_tid`, `cw_addr`, `cw_mask` and `cw_data` stay unchanged until `cw_ready` is high, even when the other thread becomes eligible meanwhile.
- R6: When both threads have an eligible head entry and no write is stalled, the grant goes to the thread that was not granted last. After reset, thread 0 wins the first tie.
- R7: A probe with `ld_valid` considers the entries of `ld_tid` that are older than `ld_tail` and have an address, and picks the youngest one whose word address equals `ld_addr` and whose byte mask overlaps `ld_mask`. If that entry has data and its mask covers every bit of `ld_mask`, `ld_hit` is high and `ld_data` is its data word.
- R8: Entries of the other thread never produce `ld_hit` or `ld_block`.
- R9: If the picked entry lacks data, or its mask misses some byte of `ld_mask`, then `ld_block` is high and `ld_hit` is low.
- R10: A flush of a thread discards its non-retired entries, so that thread's next allocation reuses the first discarded slot. Its retired entries still drain. A retire in the same cycle takes effect before the flush.
- R11: After reset, both halves are empty: `alloc_ready` is high, `cw_valid` is low, and probes return neither hit nor block.
- R12: Stores of the same thread at or after `ld_tail` are ignored by the probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Thread requesting a slot |
| alloc_ready | output | 1 | Slot available for `alloc_tid` |
| alloc_idx | output | IW | Slot granted within the thread's half |
| sta_valid | input | 1 | Store-address write |
| sta_tid | input | 1 | Thread of the address write |
| sta_idx | input | IW | Slot written |
| sta_addr | input | ADDR_W | Word address |
| sta_mask | input | BYTES | Byte enables |
| std_valid | input | 1 | Store-data write |
| std_tid | input | 1 | Thread of the data write |
| std_idx | input | IW | Slot written |
| std_data | input | DATA_W | Store data |
| ret_valid | input | 1 | Retire the oldest non-retired store |
| ret_tid | input | 1 | Thread retiring |
| flush_valid | input | 1 | Discard speculative stores |
| flush_tid | input | 1 | Thread flushed |
| ld_valid | input | 1 | Forwarding probe |
| ld_tid | input | 1 | Thread of the load |
| ld_tail | input | IW+1 | Allocation pointer (with wrap bit) seen by the load at issue |
| ld_addr | input | ADDR_W | Load word address |
| ld_mask | input | BYTES | Load byte enables |
| ld_hit | output | 1 | Data forwarded |
| ld_block | output | 1 | Load must replay |
| ld_data | output | DATA_W | Forwarded data word |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache accepts the write |
| cw_tid | output | 1 | Thread of the write |
| cw_addr | output | ADDR_W | Write word address |
| cw_mask | output | BYTES | Write byte enables |
| cw_data | output | DATA_W | Write data |

## Verification
`alloc_ready`, `alloc_idx`, the probe results and the cache write port are combinational views of the stored state. They are due in the same cycle as the inputs that select them. Every write, retire, flush, allocation and accepted cache write changes that state at the next rising edge, so its effect first shows in the following cycle. The bench drives inputs at the falling edge, compares all outputs 1 ns later against a model updated at the same rising edge, and only then advances the model. A retired entry therefore appears on the write port in the cycle after its retire.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_THR = 2;

  typedef logic tid_t;

  typedef enum logic [1:0] {
    FWD_NONE  = 2'd0,
    FWD_HIT   = 2'd1,
    FWD_BLOCK = 2'd2
  } fwd_res_e;
endpackage

// File: rtl/sb_half.sv
module sb_half #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  output logic              full,
  output logic [IW-1:0]     alloc_slot,
  input  logic              sta_en,
  input  logic [IW-1:0]     sta_slot,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [BYTES-1:0]  sta_mask,
  input  logic              std_en,
  input  logic [IW-1:0]     std_slot,
  input  logic [DATA_W-1:0] std_data,
  input  logic              ret_en,
  input  logic              flush_en,
  input  logic              com_en,
  output logic              head_req,
  output logic [ADDR_W-1:0] head_addr,
  output logic [BYTES-1:0]  head_mask,
  output logic [DATA_W-1:0] head_data,
  input  logic [PW-1:0]     ld_tail,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BYTES-1:0]  ld_mask,
  output sb_pkg::fwd_res_e  fwd_res,
  output logic [DATA_W-1:0] fwd_data
);
  logic [PW-1:0]     alloc_p, ret_p, com_p, ret_nxt, used, ld_dist;
  logic [DEPTH-1:0]  has_a, has_d;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [BYTES-1:0]  mask_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [IW-1:0]     head_i, scan_i, pick_i;
  logic              pick_ok, ret_ok;

  assign used       = alloc_p - com_p;
  assign full       = (used == PW'(DEPTH));
  assign alloc_slot = alloc_p[IW-1:0];
  assign head_i     = com_p[IW-1:0];
  assign head_req   = (com_p != ret_p) && has_a[head_i] && has_d[head_i];
  assign head_addr  = addr_q[head_i];
  assign head_mask  = mask_q[head_i];
  assign head_data  = data_q[head_i];
  assign ret_ok     = ret_en && (ret_p != alloc_p);
  assign ret_nxt    = ret_p + PW'(ret_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_p <= '0;
      ret_p   <= '0;
      com_p   <= '0;
      has_a   <= '0;
      has_d   <= '0;
    end else begin
      if (alloc_en) begin
        has_a[alloc_slot] <= 1'b0;
        has_d[alloc_slot] <= 1'b0;
        alloc_p <= alloc_p + PW'(1);
      end
      if (sta_en) has_a[sta_slot] <= 1'b1;
      if (std_en) has_d[std_slot] <= 1'b1;
      ret_p <= ret_nxt;
      if (flush_en) alloc_p <= ret_nxt;
      if (com_en) com_p <= com_p + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (sta_en) begin
      addr_q[sta_slot] <= sta_addr;
      mask_q[sta_slot] <= sta_mask;
    end
    if (std_en) data_q[std_slot] <= std_data;
  end

  // Scan from oldest to youngest; a later match overrides an earlier one.
  assign ld_dist = ld_tail - com_p;
  always_comb begin
    pick_ok = 1'b0;
    pick_i  = '0;
    scan_i  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scan_i = head_i + IW'(k);
      if ((PW'(k) < ld_dist) && has_a[scan_i] && (addr_q[scan_i] == ld_addr) &&
          ((mask_q[scan_i] & ld_mask) != '0)) begin
        pick_ok = 1'b1;
        pick_i  = scan_i;
      end
    end
  end

  always_comb begin
    fwd_res  = sb_pkg::FWD_NONE;
    fwd_data = data_q[pick_i];
    if (pick_ok) begin
      if (has_d[pick_i] && ((mask_q[pick_i] & ld_mask) == ld_mask))
        fwd_res = sb_pkg::FWD_HIT;
      else
        fwd_res = sb_pkg::FWD_BLOCK;
    end
  end
endmodule

// File: rtl/sb_commit_arb.sv
module sb_commit_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       ready,
  output logic       valid,
  output logic       gnt
);
  logic last_q, lock_q, lock_tid_q, pick;

  assign pick  = (req == 2'b11) ? ~last_q : req[1];
  assign gnt   = lock_q ? lock_tid_q : pick;
  assign valid = |req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= 1'b1;
      lock_q     <= 1'b0;
      lock_tid_q <= 1'b0;
    end else if (valid && ready) begin
      last_q <= gnt;
      lock_q <= 1'b0;
    end else if (valid) begin
      lock_q     <= 1'b1;
      lock_tid_q <= gnt;
    end
  end
endmodule

// File: rtl/smt_store_buffer.sv
module smt_store_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_tid,
  output logic              alloc_ready,
  output logic [IW-1:0]     alloc_idx,
  input  logic              sta_valid,
  input  logic              sta_tid,
  input  logic [IW-1:0]     sta_idx,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [BYTES-1:0]  sta_mask,
  input  logic              std_valid,
  input  logic              std_tid,
  input  logic [IW-1:0]     std_idx,
  input  logic [DATA_W-1:0] std_data,
  input  logic              ret_valid,
  input  logic              ret_tid,
  input  logic              flush_valid,
  input  logic              flush_tid,
  input  logic              ld_valid,
  input  logic              ld_tid,
  input  logic [PW-1:0]     ld_tail,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BYTES-1:0]  ld_mask,
  output logic              ld_hit,
  output logic              ld_block,
  output logic [DATA_W-1:0] ld_data,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic              cw_tid,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [BYTES-1:0]  cw_mask,
  output logic [DATA_W-1:0] cw_data
);
  import sb_pkg::*;

  logic [NUM_THR-1:0] h_full, h_req, h_alloc, h_com;
  logic [IW-1:0]      h_slot  [NUM_THR];
  logic [ADDR_W-1:0]  h_addr  [NUM_THR];
  logic [BYTES-1:0]   h_mask  [NUM_THR];
  logic [DATA_W-1:0]  h_data  [NUM_THR];
  logic [DATA_W-1:0]  h_fdata [NUM_THR];
  fwd_res_e           h_fres  [NUM_THR];
  logic               gnt;

  assign alloc_ready = !h_full[alloc_tid] && !(flush_valid && (flush_tid == alloc_tid));
  assign alloc_idx   = h_slot[alloc_tid];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_half
    assign h_alloc[t] = alloc_valid && alloc_ready && (alloc_tid == tid_t'(t));
    assign h_com[t]   = cw_valid && cw_ready && (gnt == tid_t'(t));

    sb_half #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) half_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (h_alloc[t]),
      .full       (h_full[t]),
      .alloc_slot (h_slot[t]),
      .sta_en     (sta_valid && (sta_tid == tid_t'(t))),
      .sta_slot   (sta_idx),
      .sta_addr   (sta_addr),
      .sta_mask   (sta_mask),
      .std_en     (std_valid && (std_tid == tid_t'(t))),
      .std_slot   (std_idx),
      .std_data   (std_data),
      .ret_en     (ret_valid && (ret_tid == tid_t'(t))),
      .flush_en   (flush_valid && (flush_tid == tid_t'(t))),
      .com_en     (h_com[t]),
      .head_req   (h_req[t]),
      .head_addr  (h_addr[t]),
      .head_mask  (h_mask[t]),
      .head_data  (h_data[t]),
      .ld_tail    (ld_tail),
      .ld_addr    (ld_addr),
      .ld_mask    (ld_mask),
      .fwd_res    (h_fres[t]),
      .fwd_data   (h_fdata[t])
    );
  end

  // Only the probing thread's half is consulted.
  assign ld_hit   = ld_valid && (h_fres[ld_tid] == FWD_HIT);
  assign ld_block = ld_valid && (h_fres[ld_tid] == FWD_BLOCK);
  assign ld_data  = ld_hit ? h_fdata[ld_tid] : '0;

  sb_commit_arb arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (h_req),
    .ready (cw_ready),
    .valid (cw_valid),
    .gnt   (gnt)
  );

  assign cw_tid  = gnt;
  assign cw_addr = h_addr[gnt];
  assign cw_mask = h_mask[gnt];
  assign cw_data = h_data[gnt];
endmodule

// File: rtl/smt_store_buffer_chk.sv
module smt_store_buffer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic              ret_tid,
  input logic              ld_valid,
  input logic              ld_hit,
  input logic              ld_block,
  input logic              cw_valid,
  input logic              cw_ready,
  input logic              cw_tid,
  input logic [ADDR_W-1:0] cw_addr,
  input logic [DATA_W-1:0] cw_data
);
  logic [7:0] retired_cnt [2];

  for (genvar t = 0; t < 2; t++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) retired_cnt[t] <= '0;
      else retired_cnt[t] <= retired_cnt[t]
                             + 8'(ret_valid && (ret_tid == 1'(t)))
                             - 8'(cw_valid && cw_ready && (cw_tid == 1'(t)));
    end
  end

  AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_tid) && $stable(cw_addr) && $stable(cw_data)); // R5

  AST_RETIRED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> retired_cnt[cw_tid] != 8'd0); // R3

  AST_HIT_XOR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_block)); // R9

  AST_PROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hit && !ld_block); // R7
endmodule

bind smt_store_buffer smt_store_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ret_valid (ret_valid),
  .ret_tid   (ret_tid),
  .ld_valid  (ld_valid),
  .ld_hit    (ld_hit),
  .ld_block  (ld_block),
  .cw_valid  (cw_valid),
  .cw_ready  (cw_ready),
  .cw_tid    (cw_tid),
  .cw_addr   (cw_addr),
  .cw_data   (cw_data)
);

// File: tb/smt_store_buffer_tb.sv
module smt_store_buffer_tb_top;
  localparam int N = 4, AW = 16, DW = 32, BW = 4, IW = 2, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic alloc_valid, alloc_tid, alloc_ready; logic [IW-1:0] alloc_idx;
  logic sta_valid, sta_tid; logic [IW-1:0] sta_idx; logic [AW-1:0] sta_addr; logic [BW-1:0] sta_mask;
  logic std_valid, std_tid; logic [IW-1:0] std_idx; logic [DW-1:0] std_data;
  logic ret_valid, ret_tid, flush_valid, flush_tid;
  logic ld_valid, ld_tid; logic [PW-1:0] ld_tail; logic [AW-1:0] ld_addr; logic [BW-1:0] ld_mask;
  logic ld_hit, ld_block; logic [DW-1:0] ld_data;
  logic cw_valid, cw_ready, cw_tid; logic [AW-1:0] cw_addr; logic [BW-1:0] cw_mask; logic [DW-1:0] cw_data;

  smt_store_buffer #(.DEPTH(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench model of the queue state, kept from the requirements.
  logic [AW-1:0] m_addr [2][N];
  logic [BW-1:0] m_mask [2][N];
  logic [DW-1:0] m_data [2][N];
  bit m_ha [2][N];
  bit m_hd [2][N];
  int m_alloc [2], m_ret [2], m_com [2];
  bit m_last, m_lock, m_lock_tid;
  int ld_tail_abs;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_full(int t); return (m_alloc[t] - m_com[t]) == N; endfunction
  function automatic bit m_req(int t);
    int s = m_com[t] % N;
    return (m_com[t] < m_ret[t]) && m_ha[t][s] && m_hd[t][s];
  endfunction
  function automatic bit m_gnt();
    if (m_lock) return m_lock_tid;
    if (m_req(0) && m_req(1)) return !m_last;
    return m_req(1);
  endfunction

  task automatic idle();
    alloc_valid = 0; alloc_tid = 0; sta_valid = 0; sta_tid = 0; sta_idx = 0; sta_addr = 0; sta_mask = 0;
    std_valid = 0; std_tid = 0; std_idx = 0; std_data = 0; ret_valid = 0; ret_tid = 0;
    flush_valid = 0; flush_tid = 0; ld_valid = 0; ld_tid = 0; ld_tail = 0; ld_addr = 0; ld_mask = 0;
    cw_ready = 0; ld_tail_abs = 0;
  endtask

  // Caller sets inputs at a falling edge; outputs are checked 1 ns later,
  // the model advances at the rising edge, inputs are cleared at the next falling edge.
  task automatic step(input string ph);
    bit e_ready, e_cwv, e_g, e_hit, e_blk, fnd;
    int fs, t;
    logic [DW-1:0] e_data;
    #1;
    t = alloc_tid;
    e_ready = !m_full(t) && !(flush_valid && flush_tid == alloc_tid);
    chk(alloc_ready == e_ready, "R1", {ph, " alloc_ready"}, alloc_ready, e_ready);
    if (e_ready) chk(alloc_idx == IW'(m_alloc[t] % N), "R1", {ph, " alloc_idx"}, alloc_idx, m_alloc[t] % N);
    e_cwv = m_req(0) || m_req(1);
    e_g = m_gnt();
    chk(cw_valid == e_cwv, "R3", {ph, " cw_valid"}, cw_valid, e_cwv);
    if (e_cwv) begin
      fs = m_com[e_g] % N;
      chk(cw_tid == e_g, "R6", {ph, " cw_tid"}, cw_tid, e_g);
      chk(cw_addr == m_addr[e_g][fs] && cw_mask == m_mask[e_g][fs], "R4", {ph, " cw_addr/mask"},
          {cw_mask, cw_addr}, {m_mask[e_g][fs], m_addr[e_g][fs]});
      chk(cw_data == m_data[e_g][fs], "R4", {ph, " cw_data"}, cw_data, m_data[e_g][fs]);
    end
    e_hit = 0; e_blk = 0; e_data = 0; fnd = 0; fs = 0;
    if (ld_valid) begin
      t = ld_tid;
      for (int p = m_com[t]; p < ld_tail_abs; p++) begin
        int s = p % N;
        if (m_ha[t][s] && m_addr[t][s] == ld_addr && (m_mask[t][s] & ld_mask) != 0) begin
          fnd = 1; fs = s;
        end
      end
      if (fnd) begin
        if (m_hd[t][fs] && (m_mask[t][fs] & ld_mask) == ld_mask) begin e_hit = 1; e_data = m_data[t][fs]; end
        else e_blk = 1;
      end
    end
    chk(ld_hit == e_hit, "R7", {ph, " ld_hit"}, ld_hit, e_hit);
    chk(ld_block == e_blk, "R9", {ph, " ld_block"}, ld_block, e_blk);
    if (e_hit) chk(ld_data == e_data, "R7", {ph, " ld_data"}, ld_data, e_data);
    @(posedge clk);
    if (e_cwv && cw_ready) begin m_com[e_g]++; m_last = e_g; m_lock = 0; end
    else if (e_cwv) begin m_lock = 1; m_lock_tid = e_g; end
    if (alloc_valid && e_ready) begin
      m_ha[alloc_tid][m_alloc[alloc_tid] % N] = 0;
      m_hd[alloc_tid][m_alloc[alloc_tid] % N] = 0;
      m_alloc[alloc_tid]++;
    end
    if (sta_valid) begin
      m_ha[sta_tid][sta_idx] = 1; m_addr[sta_tid][sta_idx] = sta_addr; m_mask[sta_tid][sta_idx] = sta_mask;
    end
    if (std_valid) begin m_hd[std_tid][std_idx] = 1; m_data[std_tid][std_idx] = std_data; end
    if (ret_valid && m_ret[ret_tid] < m_alloc[ret_tid]) m_ret[ret_tid]++;
    if (flush_valid) m_alloc[flush_tid] = m_ret[flush_tid];
    @(negedge clk);
    idle();
  endtask

  task automatic do_alloc(input bit t, input string ph);
    alloc_valid = 1; alloc_tid = t; step(ph);
  endtask
  task automatic do_sta(input bit t, input int s, input logic [AW-1:0] a, input logic [BW-1:0] m, input string ph);
    sta_valid = 1; sta_tid = t; sta_idx = IW'(s); sta_addr = a; sta_mask = m; step(ph);
  endtask
  task automatic do_std(input bit t, input int s, input logic [DW-1:0] d, input string ph);
    std_valid = 1; std_tid = t; std_idx = IW'(s); std_data = d; step(ph);
  endtask
  task automatic do_ld(input bit t, input int tail, input logic [AW-1:0] a, input logic [BW-1:0] m, input string ph);
    ld_valid = 1; ld_tid = t; ld_tail_abs = tail; ld_tail = PW'(tail % (2 * N)); ld_addr = a; ld_mask = m;
    step(ph);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_alloc[t] = 0; m_ret[t] = 0; m_com[t] = 0;
      for (int s = 0; s < N; s++) begin
        m_ha[t][s] = 0; m_hd[t][s] = 0; m_addr[t][s] = 0; m_mask[t][s] = 0; m_data[t][s] = 0;
      end
    end
    m_last = 1; m_lock = 0; m_lock_tid = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: empty after reset
    ld_valid = 1; ld_tid = 0; ld_tail = 0; ld_addr = 16'h10; ld_mask = 4'hF; step("R11 reset");
    // R1: fill thread 0, thread 1 unaffected
    for (int i = 0; i < N; i++) do_alloc(0, "R1 fill");
    do_alloc(0, "R1 full t0");
    do_alloc(1, "R1 t1 free");
    // R2: data before address on slot 0, address before data on slot 1
    do_std(0, 0, 32'hAAAA0000, "R2 data first");
    do_sta(0, 0, 16'h10, 4'hF, "R2 addr second");
    do_sta(0, 1, 16'h10, 4'h3, "R2 addr first");
    // R9: slot 1 matches but lacks data
    do_ld(0, 2, 16'h10, 4'h1, "R9 no data");
    do_std(0, 1, 32'hBBBB1111, "R2 data second");
    // R7 youngest older; R9 partial cover; R12 younger ignored; R8 sibling
    do_ld(0, 2, 16'h10, 4'h3, "R7 youngest");
    do_ld(0, 2, 16'h10, 4'hF, "R9 partial");
    do_ld(0, 1, 16'h10, 4'h3, "R12 younger ignored");
    do_ld(1, 1, 16'h10, 4'h3, "R8 sibling");
    // R3: complete but unretired never offered
    step("R3 unretired");
    ret_valid = 1; ret_tid = 0; step("R3 retire");
    ret_valid = 1; ret_tid = 0; step("R4 retire");
    // R5: stall write port while thread 1 becomes eligible
    do_sta(1, 0, 16'h20, 4'hF, "R5 setup");
    do_std(1, 0, 32'hCCCC2222, "R5 setup");
    ret_valid = 1; ret_tid = 1; step("R5 setup");
    repeat (3) step("R5 hold");
    // R6: alternate with ready high
    repeat (3) begin cw_ready = 1; step("R6 alternate"); end
    // R10: retire one, flush the rest
    do_sta(0, 2, 16'h30, 4'hF, "R10 setup");
    do_std(0, 2, 32'h1234, "R10 setup");
    ret_valid = 1; ret_tid = 0; flush_valid = 1; flush_tid = 0; alloc_valid = 1; alloc_tid = 0;
    step("R10 flush with retire");
    do_alloc(0, "R10 realloc");
    repeat (3) begin cw_ready = 1; step("R10 drain"); end

    // Constrained random phase
    void'($urandom(32'd1234));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int t, s;
      cw_ready = ($urandom % 4) != 0;
      if ($urandom % 2) begin alloc_valid = 1; alloc_tid = $urandom % 2; end
      t = $urandom % 2;
      if (m_alloc[t] > m_com[t]) begin
        s = (m_com[t] + int'($urandom % (m_alloc[t] - m_com[t]))) % N;
        if (!m_ha[t][s] && ($urandom % 2)) begin
          sta_valid = 1; sta_tid = t; sta_idx = IW'(s);
          sta_addr = 16'h10 + 16'($urandom % 3); sta_mask = 4'($urandom % 15 + 1);
        end
      end
      t = $urandom % 2;
      if (m_alloc[t] > m_com[t]) begin
        s = (m_com[t] + int'($urandom % (m_alloc[t] - m_com[t]))) % N;
        if (!m_hd[t][s] && ($urandom % 2)) begin
          std_valid = 1; std_tid = t; std_idx = IW'(s); std_data = $urandom;
        end
      end
      t = $urandom % 2;
      if (m_ret[t] < m_alloc[t] && m_ha[t][m_ret[t] % N] && m_hd[t][m_ret[t] % N] && ($urandom % 3 == 0)) begin
        ret_valid = 1; ret_tid = t;
      end
      if ($urandom % 50 == 0) begin flush_valid = 1; flush_tid = $urandom % 2; end
      if ($urandom % 5 < 3) begin
        t = $urandom % 2;
        ld_valid = 1; ld_tid = t;
        ld_tail_abs = m_com[t] + int'($urandom % (m_alloc[t] - m_com[t] + 1));
        ld_tail = PW'(ld_tail_abs % (2 * N));
        ld_addr = 16'h10 + 16'($urandom % 3); ld_mask = 4'($urandom % 15 + 1);
      end
      step("random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule